// File: doc/BRIEF.md
# Teletext Bit Cadence Sequencer

This block times the capture of one line of serial teletext data against the horizontal sync of a 27 MHz video pipeline. On each sync leading edge it starts a line timer. It raises a request to the external data source before the data area begins. It then takes 360 bits from a serial input, using slots of three and four clocks. Each sampled bit is presented with a one-clock valid strobe. A single pulse marks the end of the line. Downstream filtering and mixing into the composite or luma path consume the strobed bits.

The teletext rate is not a whole fraction of the system clock. A 37-bit group takes exactly 144 clocks, and four chosen bits in each group are one clock short. Two 4-bit advance fields move the request's rising and falling edges earlier. This covers the pipeline delay of the source while the data area itself stays fixed.

Top module: `teletext_cadence_seq`

In the requirements, cycle 0 is the clock cycle that follows the rising clock edge at which `hsync_i` is first sampled high after being sampled low. A cycle number refers to the value that outputs hold during that cycle.

## Requirements
- R1: With `txt_en_i` high at the sync edge, `txt_req_o` first goes high in cycle 275 minus `req_rise_adv_i` (an unsigned value from 0 to 15).
- R2: With `txt_en_i` high, `txt_req_o` stays high through cycle 1676 minus `req_fall_adv_i`. It is low from cycle 1677 minus `req_fall_adv_i` onward.
- R3: With `txt_en_i` low at the sync edge, the line produces no `txt_req_o`, no `bit_valid_o` and no `line_done_o`.
- R4: Bit slots follow back to back from cycle 275. Counting 1 to 37 within each repeating group of 37 bits, bits 10, 19, 28 and 37 take 3 clocks and every other bit takes 4. One group spans 144 clocks.
- R5: Each bit is sampled at clock 2 of a four-clock slot or clock 1 of a three-clock slot, counting from 0. In the cycle after the sample, `bit_valid_o` is high and `bit_o` equals the value `txt_data_i` had in the sample cycle.
- R6: An enabled, uninterrupted line yields exactly 360 `bit_valid_o` pulses.
- R7: `line_done_o` pulses for one cycle in cycle 1677. This is the cycle after the last `bit_valid_o`.
- R8: A sync edge during a line abandons it. That line produces no `line_done_o`, and timing restarts from the new edge.
- R9: While `rst_ni` is low, all outputs are low. After reset no request or strobe occurs until a sync edge.
- R10: `bit_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Horizontal sync, leading edge is its rising edge |
| txt_en_i | input | 1 | Teletext enable, sampled at the sync edge |
| req_rise_adv_i | input | 4 | Clocks by which the request rising edge precedes the data area |
| req_fall_adv_i | input | 4 | Clocks by which the request falling edge precedes the data area end |
| txt_data_i | input | 1 | Serial teletext data from the source |
| txt_req_o | output | 1 | Data request to the source |
| bit_o | output | 1 | Last sampled teletext bit |
| bit_valid_o | output | 1 | One-clock strobe for `bit_o` |
| line_done_o | output | 1 | One-clock pulse after the final bit of a line |

## Verification
The request is combinational from the line timer, so its edges are due in the very cycle numbers R1 and R2 give. Each bit strobe is due one register later than its sample cycle, which is slot start plus 3 for a long slot and plus 2 for a short one. The done pulse is due one cycle after the final strobe. The bench counts cycles from the clock edge that first sees sync high. It samples outputs and drives data on falling edges, so each cycle's data is already stable when that cycle's sample is taken. It compares every cycle of each line against a slot table that it builds itself from the 3/4-clock rule.

// File: rtl/txt_seq_pkg.sv
package txt_seq_pkg;

  // Bit g (1-based within a group) is short when it closes a stride.
  function automatic bit is_short(int g, int group_bits, int stride);
    if (g < 2 || g > group_bits) return 1'b0;
    return ((g - 1) % stride) == 0;
  endfunction

  function automatic int line_clks(int bits, int group_bits, int stride, int long_clks);
    int sum;
    sum = 0;
    for (int k = 0; k < bits; k++) begin
      sum += is_short((k % group_bits) + 1, group_bits, stride) ? long_clks - 1 : long_clks;
    end
    return sum;
  endfunction

endpackage

// File: rtl/txt_line_timer.sv
module txt_line_timer #(
  parameter int START_CLKS = 275,
  parameter int END_CLKS   = 1677,
  parameter int ADV_W      = 4,
  parameter int POS_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             en_i,
  input  logic [ADV_W-1:0] rise_adv_i,
  input  logic [ADV_W-1:0] fall_adv_i,
  output logic             sync_edge_o,
  output logic             load_o,
  output logic             req_o
);

  localparam logic [POS_W-1:0] START_P = POS_W'(START_CLKS);
  localparam logic [POS_W-1:0] END_P   = POS_W'(END_CLKS);

  logic             hs_q;
  logic             run_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] rise_pos;
  logic [POS_W-1:0] fall_pos;

  assign sync_edge_o = hsync_i & ~hs_q;
  assign rise_pos    = START_P - {{(POS_W-ADV_W){1'b0}}, rise_adv_i};
  assign fall_pos    = END_P   - {{(POS_W-ADV_W){1'b0}}, fall_adv_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      run_q <= 1'b0;
      pos_q <= '0;
    end else begin
      hs_q <= hsync_i;
      if (sync_edge_o) begin
        run_q <= en_i;
        pos_q <= '0;
      end else if (run_q) begin
        if (pos_q == END_P - 1'b1) run_q <= 1'b0;
        else                       pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign load_o = run_q && (pos_q == START_P - 1'b1);
  assign req_o  = run_q && (pos_q >= rise_pos) && (pos_q < fall_pos);

endmodule

// File: rtl/txt_cadence.sv
module txt_cadence #(
  parameter int LINE_BITS    = 360,
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_CLKS    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic load_i,
  input  logic data_i,
  output logic bit_o,
  output logic valid_o,
  output logic done_o
);

  localparam int GRP_W = $clog2(GROUP_BITS + 1);
  localparam int BIT_W = $clog2(LINE_BITS);
  localparam int CLK_W = $clog2(LONG_CLKS);
  localparam int MAP_N = 2 ** GRP_W;

  logic [MAP_N-1:0] short_map;

  for (genvar g = 0; g < MAP_N; g++) begin : g_map
    assign short_map[g] = txt_seq_pkg::is_short(g, GROUP_BITS, SHORT_STRIDE);
  end

  logic             busy_q;
  logic [CLK_W-1:0] clk_q;
  logic [GRP_W-1:0] grp_q;
  logic [BIT_W-1:0] cnt_q;
  logic             bit_q, valid_q, done_q;
  logic             cur_short;
  logic [CLK_W-1:0] mid_clk, last_clk;

  assign cur_short = short_map[grp_q];
  assign mid_clk   = cur_short ? CLK_W'((LONG_CLKS - 1) / 2) : CLK_W'(LONG_CLKS / 2);
  assign last_clk  = cur_short ? CLK_W'(LONG_CLKS - 2)       : CLK_W'(LONG_CLKS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      clk_q   <= '0;
      grp_q   <= '0;
      cnt_q   <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (load_i) begin
        busy_q <= 1'b1;
        clk_q  <= '0;
        grp_q  <= GRP_W'(1);
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (clk_q == mid_clk) begin
          bit_q   <= data_i;
          valid_q <= 1'b1;
        end
        if (clk_q == last_clk) begin
          clk_q <= '0;
          grp_q <= (grp_q == GRP_W'(GROUP_BITS)) ? GRP_W'(1) : grp_q + 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == BIT_W'(LINE_BITS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          clk_q <= clk_q + 1'b1;
        end
      end
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;

endmodule

// File: rtl/teletext_cadence_seq.sv
module teletext_cadence_seq #(
  parameter int START_CLKS   = 275,
  parameter int LINE_BITS    = 360,
  parameter int GROUP_BITS   = 37,
  parameter int SHORT_STRIDE = 9,
  parameter int LONG_CLKS    = 4,
  parameter int ADV_W        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             txt_en_i,
  input  logic [ADV_W-1:0] req_rise_adv_i,
  input  logic [ADV_W-1:0] req_fall_adv_i,
  input  logic             txt_data_i,
  output logic             txt_req_o,
  output logic             bit_o,
  output logic             bit_valid_o,
  output logic             line_done_o
);

  localparam int LINE_CLKS =
    txt_seq_pkg::line_clks(LINE_BITS, GROUP_BITS, SHORT_STRIDE, LONG_CLKS);
  localparam int END_CLKS  = START_CLKS + LINE_CLKS;
  localparam int POS_W     = $clog2(END_CLKS + 1);

  logic sync_edge, load;

  txt_line_timer #(
    .START_CLKS(START_CLKS),
    .END_CLKS  (END_CLKS),
    .ADV_W     (ADV_W),
    .POS_W     (POS_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsync_i    (hsync_i),
    .en_i       (txt_en_i),
    .rise_adv_i (req_rise_adv_i),
    .fall_adv_i (req_fall_adv_i),
    .sync_edge_o(sync_edge),
    .load_o     (load),
    .req_o      (txt_req_o)
  );

  txt_cadence #(
    .LINE_BITS   (LINE_BITS),
    .GROUP_BITS  (GROUP_BITS),
    .SHORT_STRIDE(SHORT_STRIDE),
    .LONG_CLKS   (LONG_CLKS)
  ) u_cadence (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(sync_edge),
    .load_i (load),
    .data_i (txt_data_i),
    .bit_o  (bit_o),
    .valid_o(bit_valid_o),
    .done_o (line_done_o)
  );

endmodule

// File: rtl/teletext_cadence_seq_chk.sv
module teletext_cadence_seq_chk #(
  parameter int START_CLKS = 275,
  parameter int END_CLKS   = 1677,
  parameter int ADV_W      = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hsync_i,
  input logic txt_req_o,
  input logic bit_valid_o,
  input logic line_done_o
);

  logic        hs_prev;
  logic [15:0] since_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_prev    <= 1'b0;
      since_sync <= '1;
    end else begin
      hs_prev <= hsync_i;
      if (hsync_i && !hs_prev)   since_sync <= '0;
      else if (since_sync != '1) since_sync <= since_sync + 1'b1;
    end
  end

  assert_req_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txt_req_o |-> (since_sync >= 16'(START_CLKS - (2 ** ADV_W - 1)) && since_sync < 16'(END_CLKS)));

  assert_valid_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (since_sync >= 16'(START_CLKS + 2) && since_sync < 16'(END_CLKS)));

  assert_done_time_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> since_sync == 16'(END_CLKS));

  assert_done_after_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> $past(bit_valid_o));

  assert_abort_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_i) |=> (!line_done_o && !bit_valid_o));

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

endmodule

bind teletext_cadence_seq teletext_cadence_seq_chk #(
  .START_CLKS(START_CLKS),
  .END_CLKS  (END_CLKS),
  .ADV_W     (ADV_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hsync_i    (hsync_i),
  .txt_req_o  (txt_req_o),
  .bit_valid_o(bit_valid_o),
  .line_done_o(line_done_o)
);

// File: tb/teletext_cadence_seq_tb_top.sv
module teletext_cadence_seq_tb_top;

  localparam int DATA_START = 275;
  localparam int LINE_END   = 1677;
  localparam int NBITS      = 360;

  typedef struct packed {
    logic [3:0] rise;
    logic [3:0] fall;
    logic [8:0] seed;
    logic       en;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  4'd0,  9'h0a5, 1'b1},
    '{4'd15, 4'd15, 9'h13c, 1'b1},
    '{4'd7,  4'd3,  9'h07e, 1'b1},
    '{4'd2,  4'd0,  9'h1ff, 1'b0},
    '{4'd0,  4'd12, 9'h055, 1'b1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hsync_i = 1'b0;
  logic       txt_en_i = 1'b0;
  logic [3:0] req_rise_adv_i = '0;
  logic [3:0] req_fall_adv_i = '0;
  logic       txt_data_i = 1'b0;
  logic       txt_req_o, bit_o, bit_valid_o, line_done_o;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  int slot_s [NBITS];
  int slot_l [NBITS];
  int vcyc   [NBITS];
  int obs    [NBITS];

  always #5 clk_i = ~clk_i;

  teletext_cadence_seq dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hsync_i       (hsync_i),
    .txt_en_i      (txt_en_i),
    .req_rise_adv_i(req_rise_adv_i),
    .req_fall_adv_i(req_fall_adv_i),
    .txt_data_i    (txt_data_i),
    .txt_req_o     (txt_req_o),
    .bit_o         (bit_o),
    .bit_valid_o   (bit_valid_o),
    .line_done_o   (line_done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pat(input int k, input logic [8:0] seed);
    int v;
    v = k * 37 + int'(seed) + (k >> 3);
    return v[3] ^ v[0];
  endfunction

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", wd, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Caller is positioned at a falling edge; hsync_i must be low.
  task automatic run_line(input logic [3:0] rise, input logic [3:0] fall,
                          input logic [8:0] seed, input logic en, input int abort_at);
    int p, di, vi, vcount, rise_at, fall_at, req_bad, t_bad, b_bad, done_cnt, done_at, back2back;
    logic prev_v;
    int p_end;
    p_end = (abort_at > 0) ? abort_at : LINE_END + 4;
    di = 0; vi = 0; vcount = 0; rise_at = -1; fall_at = -1;
    req_bad = 0; t_bad = 0; b_bad = 0; done_cnt = 0; done_at = -1; back2back = 0;
    prev_v = 1'b0;
    txt_en_i       = en;
    req_rise_adv_i = rise;
    req_fall_adv_i = fall;
    hsync_i        = 1'b1;
    @(posedge clk_i);
    for (p = 0; p <= p_end; p++) begin
      @(negedge clk_i);
      if (p == 8) hsync_i = 1'b0;
      begin
        logic req_exp, v_exp;
        req_exp = en && p >= DATA_START - int'(rise) && p < LINE_END - int'(fall);
        if (txt_req_o !== req_exp) req_bad++;
        if (txt_req_o && rise_at < 0) rise_at = p;
        if (!txt_req_o && rise_at >= 0 && fall_at < 0) fall_at = p;
        v_exp = en && vi < NBITS && p == vcyc[vi];
        if (bit_valid_o !== v_exp) t_bad++;
        if (bit_valid_o && prev_v) back2back++;
        prev_v = bit_valid_o;
        if (bit_valid_o) begin
          if (vcount < NBITS) obs[vcount] = p;
          vcount++;
        end
        if (v_exp) begin
          if (bit_o !== pat(vi, seed)) b_bad++;
          vi++;
        end
        if (line_done_o) begin
          done_cnt++;
          if (done_at < 0) done_at = p;
        end
      end
      while (di < NBITS && p >= slot_s[di] + slot_l[di]) di++;
      if (di < NBITS && p >= slot_s[di]) txt_data_i = pat(di, seed);
      else                               txt_data_i = p[1];
    end
    if (abort_at > 0) begin
      chk(done_cnt == 0, "R8", "aborted line done pulses", done_cnt, 0);
      chk(t_bad == 0, "R5", "strobe timing before abort, mismatching cycles", t_bad, 0);
    end else if (!en) begin
      chk(req_bad == 0 && rise_at < 0, "R3", "request cycles while disabled", req_bad, 0);
      chk(vcount == 0, "R3", "strobes while disabled", vcount, 0);
      chk(done_cnt == 0, "R3", "done pulses while disabled", done_cnt, 0);
    end else begin
      chk(rise_at == DATA_START - int'(rise), "R1", "request rise cycle", rise_at, DATA_START - int'(rise));
      chk(fall_at == LINE_END - int'(fall), "R2", "request fall cycle", fall_at, LINE_END - int'(fall));
      chk(req_bad == 0, "R2", "request window mismatching cycles", req_bad, 0);
      chk(t_bad == 0, "R5", "strobe timing mismatching cycles", t_bad, 0);
      chk(b_bad == 0, "R5", "sampled bit mismatches", b_bad, 0);
      chk(vcount == NBITS, "R6", "strobe count", vcount, NBITS);
      chk(done_cnt == 1 && done_at == LINE_END, "R7", "done cycle", done_at, LINE_END);
      chk(back2back == 0, "R10", "back-to-back strobes", back2back, 0);
      if (vcount >= 38) begin
        chk(obs[0] == DATA_START + 3, "R4", "first strobe cycle", obs[0], DATA_START + 3);
        chk(obs[9] == 313, "R4", "strobe of short bit 10", obs[9], 313);
        chk(obs[10] == 317, "R4", "strobe of bit 11", obs[10], 317);
        chk(obs[37] - obs[0] == 144, "R4", "clocks per 37-bit group", obs[37] - obs[0], 144);
      end
    end
  endtask

  initial begin
    // Independent slot table from the 3/4-clock rule
    begin
      int s;
      s = DATA_START;
      for (int k = 0; k < NBITS; k++) begin
        int g;
        g = (k % 37) + 1;
        slot_s[k] = s;
        slot_l[k] = (g == 10 || g == 19 || g == 28 || g == 37) ? 3 : 4;
        vcyc[k]   = s + ((slot_l[k] == 4) ? 2 : 1) + 1;
        s += slot_l[k];
      end
    end

    // R9: reset state
    repeat (3) @(negedge clk_i);
    chk({txt_req_o, bit_valid_o, line_done_o, bit_o} == 4'b0, "R9", "outputs in reset",
        int'({txt_req_o, bit_valid_o, line_done_o, bit_o}), 0);
    rst_ni = 1'b1;
    txt_en_i = 1'b1;
    begin
      int busy;
      busy = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk_i);
        if (txt_req_o || bit_valid_o || line_done_o) busy++;
      end
      chk(busy == 0, "R9", "activity without sync after reset", busy, 0);
    end

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      run_line(VECS[i].rise, VECS[i].fall, VECS[i].seed, VECS[i].en, 0);
      repeat (20) @(negedge clk_i);
    end

    // R8: abort mid-line, then a full line from the new edge
    run_line(4'd0, 4'd0, 9'h0c3, 1'b1, 700);
    run_line(4'd5, 4'd1, 9'h111, 1'b1, 0);

    // R8: abort during the final bits
    repeat (5) @(negedge clk_i);
    run_line(4'd0, 4'd0, 9'h099, 1'b1, 1670);
    run_line(4'd0, 4'd0, 9'h03a, 1'b1, 0);

    // R9: reset during a line
    repeat (5) @(negedge clk_i);
    txt_en_i = 1'b1;
    hsync_i = 1'b1;
    repeat (10) @(negedge clk_i);
    hsync_i = 1'b0;
    repeat (300) @(negedge clk_i);
    chk(txt_req_o == 1'b1, "R1", "request high mid-line before reset", int'(txt_req_o), 1);
    rst_ni = 1'b0;
    #1;
    chk({txt_req_o, bit_valid_o, line_done_o, bit_o} == 4'b0, "R9", "outputs after async reset",
        int'({txt_req_o, bit_valid_o, line_done_o, bit_o}), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    begin
      int busy;
      busy = 0;
      for (int i = 0; i < 1800; i++) begin
        @(negedge clk_i);
        if (txt_req_o || bit_valid_o || line_done_o) busy++;
      end
      chk(busy == 0, "R9", "activity after reset mid-line", busy, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule